// File: doc/BRIEF.md
# Counter-Based PLL Lock Detector

This block decides whether a phase-locked loop has settled. It looks only at the loop's reference clock and its generated clock and does not use any internal signal of the loop. Each clock drives its own free-running counter. A measurement window is exactly 2^CNT_W reference cycles long and closes when the reference counter wraps to zero. At that point the generated-clock domain captures its count and restarts from one, so consecutive captures lie exactly one window apart. The captured count, read modulo 2^CNT_W as a two's-complement number, is the frequency slip over the window. For a 1:1 loop a locked clock reads zero.

Each slip is compared with a symmetric tolerance. The lock flag rises only after LOCK_WINDOWS good windows in a row, and a single bad window drops it. The window request and the capture acknowledge cross between the domains as toggles through two-flop synchronisers. The held count does not change while the reference side samples it. The first capture after reset is thrown away because the two counters were not aligned for it.

Top module: `pll_lock_detect`

## Requirements
- R1: While rst_n is low at a reference clock edge, locked and win_done are 0 and slip is 0 after that edge.
- R2: In steady state with a fixed clock ratio, win_done pulses exactly 2^CNT_W reference cycles apart.
- R3: The first window after reset is discarded: the first win_done comes no earlier than 2*2^CNT_W reference cycles after reset is released.
- R4: On the cycle win_done is high, slip holds the number of generated-clock edges in the window modulo 2^CNT_W, as a two's-complement value (e.g. 320 edges read +64, 200 edges read -56 for CNT_W = 8).
- R5: A window is good when -SLIP_TOL <= slip <= SLIP_TOL, both bounds included. While locked is high, the latest slip is good.
- R6: locked rises one reference cycle after the win_done of the LOCK_WINDOWS-th consecutive good window, and not earlier.
- R7: locked falls one reference cycle after the win_done of any bad window.
- R8: A bad window clears the good-window count. After it, LOCK_WINDOWS new good windows are needed before locked rises again.
- R9: win_done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all outputs are in this domain |
| out_clk | input | 1 | PLL generated clock under observation |
| rst_n | input | 1 | Synchronous active-low reset, in the reference domain |
| locked | output | 1 | Lock flag with N-window qualification |
| slip | output | CNT_W | Two's-complement slip of the latest window |
| win_done | output | 1 | One-cycle strobe marking a new slip value |

## Verification
The reference counter wraps, then two generated-clock synchroniser stages respond, then two reference synchroniser stages and an edge register follow. After that, slip and win_done update on the same reference edge. locked follows one reference cycle later. The bench samples every output at the falling reference edge and treats each observed win_done as the event. It checks slip and the strobe spacing at that edge. It updates its own qualifier model there and compares locked from the next falling edge onward. When the generated period changes mid-run, the window that spans the change has no exact slip or spacing, so the bench checks only its good or bad class.

// File: rtl/pll_lock_pkg.sv
// Package: shared constants for the PLL lock detector.
// Assumes: two synchroniser stages are enough for the target process.
package pll_lock_pkg;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/lock_bit_sync.sv
// Module: lock_bit_sync
// Carries one level or toggle signal into the clk domain through a flop chain.
// Assumes: d changes at most once per few clk cycles (toggle protocol).
module lock_bit_sync #(
    parameter int STAGES = pll_lock_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lock_out_side.sv
// Module: lock_out_side
// Generated-clock domain: counts edges, and on each window request holds the
// count, restarts the counter at one and toggles the acknowledge.
// Assumes: rst_n comes from the reference domain and is resynchronised here;
// requests arrive far less often than the round-trip latency.
module lock_out_side #(
    parameter int CNT_W = 8
) (
    input  logic             out_clk,
    input  logic             rst_n,
    input  logic             req_tgl,
    output logic [CNT_W-1:0] hold,
    output logic             ack_tgl
);
    logic [1:0]       rst_pipe;
    logic             out_rst_n;
    logic             req_s;
    logic             req_d;
    logic             capture;
    logic [CNT_W-1:0] cnt;

    // Bring the reference-domain reset into this domain.
    always_ff @(posedge out_clk) begin
        rst_pipe <= {rst_pipe[0], rst_n};
    end
    assign out_rst_n = rst_pipe[1];

    lock_bit_sync u_req_sync (
        .clk   (out_clk),
        .rst_n (out_rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    // Remember the last synchronised request level for edge detection.
    always_ff @(posedge out_clk) begin
        if (!out_rst_n) req_d <= 1'b0;
        else            req_d <= req_s;
    end
    assign capture = req_s ^ req_d;

    // Count edges; the capture edge counts as the first edge of the next window.
    always_ff @(posedge out_clk) begin
        if (!out_rst_n)   cnt <= '0;
        else if (capture) cnt <= CNT_W'(1);
        else              cnt <= cnt + 1'b1;
    end

    // Hold the closing count and answer the request.
    always_ff @(posedge out_clk) begin
        if (!out_rst_n) begin
            hold    <= '0;
            ack_tgl <= 1'b0;
        end else if (capture) begin
            hold    <= cnt;
            ack_tgl <= ~ack_tgl;
        end
    end
endmodule

// File: rtl/lock_ref_side.sv
// Module: lock_ref_side
// Reference domain: times the windows, requests captures and samples the held
// count when the acknowledge arrives. Drops the first capture after reset.
// Assumes: hold is stable from the acknowledge toggle until the next request.
module lock_ref_side #(
    parameter int CNT_W = 8
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             ack_tgl,
    input  logic [CNT_W-1:0] hold,
    output logic             req_tgl,
    output logic [CNT_W-1:0] slip,
    output logic             win_done
);
    logic [CNT_W-1:0] ref_cnt;
    logic             wrap;
    logic             ack_s;
    logic             ack_d;
    logic             ack_edge;
    logic             primed;

    assign wrap = &ref_cnt;

    // Free-running window timer; toggle a request each time it wraps.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            req_tgl <= 1'b0;
        end else begin
            ref_cnt <= ref_cnt + 1'b1;
            req_tgl <= req_tgl ^ wrap;
        end
    end

    lock_bit_sync u_ack_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    // Keep the last acknowledge level for edge detection.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) ack_d <= 1'b0;
        else        ack_d <= ack_s;
    end
    assign ack_edge = ack_s ^ ack_d;

    // Sample the held count; the first capture only arms the path.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            primed   <= 1'b0;
            slip     <= '0;
            win_done <= 1'b0;
        end else begin
            win_done <= ack_edge & primed;
            if (ack_edge) begin
                primed <= 1'b1;
                if (primed) slip <= hold;
            end
        end
    end
endmodule

// File: rtl/lock_qualifier.sv
// Module: lock_qualifier
// Classifies each window against the tolerance and qualifies the lock flag.
// Assumes: slip is valid whenever win_done is high.
module lock_qualifier #(
    parameter int CNT_W        = 8,
    parameter int LOCK_WINDOWS = 4,
    parameter int SLIP_TOL     = 1
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             win_done,
    input  logic [CNT_W-1:0] slip,
    output logic             locked
);
    localparam int                      QW    = $clog2(LOCK_WINDOWS + 1);
    localparam logic [QW-1:0]           QMAX  = QW'(LOCK_WINDOWS);
    localparam logic signed [CNT_W-1:0] TOL_P = CNT_W'(SLIP_TOL);

    logic signed [CNT_W-1:0] slip_s;
    logic                    good;
    logic [QW-1:0]           qual;

    assign slip_s = $signed(slip);
    assign good   = (slip_s <= TOL_P) && (slip_s >= -TOL_P);

    // Count consecutive good windows (saturating) and drive the lock flag.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            qual   <= '0;
            locked <= 1'b0;
        end else if (win_done) begin
            if (!good) begin
                qual   <= '0;
                locked <= 1'b0;
            end else if (qual != QMAX) begin
                qual   <= qual + 1'b1;
                locked <= (qual + 1'b1 == QMAX);
            end else begin
                locked <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pll_lock_detect.sv
// Module: pll_lock_detect (top)
// Judges PLL lock from the reference and generated clocks alone.
// Assumes: CNT_W >= 4 so a window is far longer than the handshake round trip.
module pll_lock_detect #(
    parameter int CNT_W        = 8,
    parameter int LOCK_WINDOWS = 4,
    parameter int SLIP_TOL     = 1
) (
    input  logic             ref_clk,
    input  logic             out_clk,
    input  logic             rst_n,
    output logic             locked,
    output logic [CNT_W-1:0] slip,
    output logic             win_done
);
    logic             req_tgl;
    logic             ack_tgl;
    logic [CNT_W-1:0] hold;

    lock_ref_side #(.CNT_W(CNT_W)) u_ref (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .ack_tgl  (ack_tgl),
        .hold     (hold),
        .req_tgl  (req_tgl),
        .slip     (slip),
        .win_done (win_done)
    );

    lock_out_side #(.CNT_W(CNT_W)) u_out (
        .out_clk (out_clk),
        .rst_n   (rst_n),
        .req_tgl (req_tgl),
        .hold    (hold),
        .ack_tgl (ack_tgl)
    );

    lock_qualifier #(
        .CNT_W        (CNT_W),
        .LOCK_WINDOWS (LOCK_WINDOWS),
        .SLIP_TOL     (SLIP_TOL)
    ) u_qual (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .win_done (win_done),
        .slip     (slip),
        .locked   (locked)
    );
endmodule

// File: rtl/pll_lock_detect_chk.sv
// Module: pll_lock_detect_chk
// Property checker bound to pll_lock_detect; watches only its ports.
// Assumes: reference-domain view; spacing margin covers a clock-ratio change.
module pll_lock_detect_chk #(
    parameter int CNT_W        = 8,
    parameter int LOCK_WINDOWS = 4,
    parameter int SLIP_TOL     = 1
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             locked,
    input logic [CNT_W-1:0] slip,
    input logic             win_done
);
    localparam int                      GW    = CNT_W + 2;
    localparam logic [GW-1:0]           WIN   = GW'(2 ** CNT_W);
    localparam logic signed [CNT_W-1:0] TOL_P = CNT_W'(SLIP_TOL);

    logic [GW-1:0] since_rst;
    logic [GW-1:0] gap;
    logic          seen_done;
    logic          slip_ok;

    assign slip_ok = ($signed(slip) <= TOL_P) && ($signed(slip) >= -TOL_P);

    // Track time since reset and since the previous strobe (saturating).
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            gap       <= '0;
            seen_done <= 1'b0;
        end else begin
            if (~&since_rst) since_rst <= since_rst + 1'b1;
            if (win_done)    gap <= GW'(1);
            else if (~&gap)  gap <= gap + 1'b1;
            if (win_done)    seen_done <= 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge ref_clk)
        !rst_n |=> (!locked && !win_done && slip == '0));

    // R2
    win_gap_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (win_done && seen_done) |-> (gap >= WIN - GW'(4)));

    // R3
    first_win_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        win_done |-> (since_rst >= (WIN << 1)));

    // R5
    lock_good_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (locked && !win_done) |-> slip_ok);

    // R6
    lock_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(win_done) && $past(slip_ok)));

    // R7
    lock_fall_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (win_done && !slip_ok) |=> !locked);

    // R9
    done_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        win_done |=> !win_done);
endmodule

bind pll_lock_detect pll_lock_detect_chk #(
    .CNT_W        (CNT_W),
    .LOCK_WINDOWS (LOCK_WINDOWS),
    .SLIP_TOL     (SLIP_TOL)
) u_chk (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .locked   (locked),
    .slip     (slip),
    .win_done (win_done)
);

// File: tb/test_pll_lock_detect.sv
`timescale 1ps/1ps
// Bench: behavioural window/qualifier model, compared at every falling ref edge.
module test_pll_lock_detect;
    localparam int W     = 8;
    localparam int WIN   = 256;
    localparam int NQ    = 4;
    localparam int TOL_A = 1;
    localparam int TOL_B = 6;

    logic ref_clk = 1'b0;
    logic out_clk;
    logic rst_n   = 1'b0;
    int unsigned out_half = 2500;

    logic         locked_a, done_a, locked_b, done_b;
    logic [W-1:0] slip_a, slip_b;

    int n_chk  = 0;
    int n_fail = 0;

    // model state
    int exp_slip   = 0;
    bit slip_exact = 1;
    int qa = 0, qb = 0;
    bit la = 0, lb = 0;
    int done_cnt = 0, cyc = 0, last_done = 0, rst_low = 0;
    bit prev_done = 0;

    always #2500 ref_clk = ~ref_clk;   // 200 MHz reference

    // Generated clock: every edge lands at 17 ps mod 20, never on a ref edge.
    initial begin
        out_clk = 1'b0;
        #1237;
        forever #(out_half) out_clk = ~out_clk;
    end

    pll_lock_detect #(.CNT_W(W), .LOCK_WINDOWS(NQ), .SLIP_TOL(TOL_A)) i_pll_lock_detect (
        .ref_clk (ref_clk), .out_clk (out_clk), .rst_n (rst_n),
        .locked (locked_a), .slip (slip_a), .win_done (done_a));

    pll_lock_detect #(.CNT_W(W), .LOCK_WINDOWS(NQ), .SLIP_TOL(TOL_B)) i_pll_lock_detect_wide (
        .ref_clk (ref_clk), .out_clk (out_clk), .rst_n (rst_n),
        .locked (locked_b), .slip (slip_b), .win_done (done_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model, evaluated at each falling edge.
    always @(negedge ref_clk) begin
        if (!rst_n) begin
            rst_low++;
            if (rst_low >= 2) begin
                check(!locked_a && !locked_b, "R1 locked in reset", int'(locked_a), 0);
                check(!done_a && slip_a == '0, "R1 done/slip in reset", int'(slip_a), 0);
            end
            qa = 0; qb = 0; la = 0; lb = 0;
            done_cnt = 0; cyc = 0; prev_done = 0; slip_exact = 1;
        end else begin
            rst_low = 0;
            cyc++;
            // R6 R7 R8: lock compared against the model every cycle
            check(locked_a == la, "R6/R7/R8 locked (tol 1)", int'(locked_a), int'(la));
            check(locked_b == lb, "R6/R7/R8 locked (tol 6)", int'(locked_b), int'(lb));
            check(!(done_a && prev_done), "R9 single-cycle strobe", int'(done_a), 0);
            check(done_a == done_b, "R2 strobes of both instances agree", int'(done_b), int'(done_a));
            if (done_a) begin
                if (done_cnt == 0)
                    check(cyc > 2 * WIN, "R3 first window discarded", cyc, 2 * WIN + 1);
                else if (slip_exact)
                    check(cyc - last_done == WIN, "R2 window spacing", cyc - last_done, WIN);
                if (slip_exact)
                    check(int'($signed(slip_a)) == exp_slip, "R4 slip value",
                          int'($signed(slip_a)), exp_slip);
                check(slip_b == slip_a, "R4 slip of both instances agree",
                      int'($signed(slip_b)), int'($signed(slip_a)));
                // R5: inclusive tolerance, qualifier model
                if (exp_slip <= TOL_A && exp_slip >= -TOL_A) begin
                    qa = (qa < NQ) ? qa + 1 : NQ; la = (qa == NQ);
                end else begin
                    qa = 0; la = 0;
                end
                if (exp_slip <= TOL_B && exp_slip >= -TOL_B) begin
                    qb = (qb < NQ) ? qb + 1 : NQ; lb = (qb == NQ);
                end else begin
                    qb = 0; lb = 0;
                end
                slip_exact = 1;
                last_done  = cyc;
                done_cnt++;
            end
            prev_done = done_a;
        end
    end

    task automatic wait_dones(input int k);
        for (int i = 0; i < k; i++) begin
            do @(negedge ref_clk); while (!done_a);
        end
        #1;
    endtask

    task automatic do_reset(input int unsigned half, input int slip_val);
        @(negedge ref_clk); #100;
        rst_n    = 1'b0;
        out_half = half;
        exp_slip = slip_val;
        repeat (5) @(negedge ref_clk);
        #100;
        rst_n = 1'b1;
    endtask

    task automatic switch_live(input int unsigned half, input int slip_val);
        out_half   = half;
        exp_slip   = slip_val;
        slip_exact = 0;
    endtask

    initial begin
        // 1:1 ratio: both lock after four windows (R6)
        do_reset(2500, 0);
        wait_dones(3);
        check(!locked_a, "R6 no lock after three good windows", int'(locked_a), 0);
        wait_dones(3);
        // faster clock mid-run: 320 edges read +64, lock drops (R7, R4)
        switch_live(2000, 64);
        wait_dones(3);
        // back to 1:1: four new good windows needed (R8)
        switch_live(2500, 0);
        wait_dones(3);
        check(!locked_a, "R8 qualifier restarted after bad window", int'(locked_a), 0);
        wait_dones(3);
        // slower clock: 200 edges read -56 (R4)
        do_reset(3200, -56);
        wait_dones(4);
        // tolerance boundary: 250 edges read -6, only the wide instance locks (R5)
        do_reset(2560, -6);
        wait_dones(6);
        check(locked_b && !locked_a, "R5 inclusive tolerance bound",
              int'({locked_b, locked_a}), 2);
        @(negedge ref_clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge ref_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", done_cnt, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule